// File: doc/BRIEF.md
# Host Cycle Address Window Decoder

This block decides whether a host I/O or memory cycle belongs to a downstream peripheral bridge. It looks at the address and type of each cycle and reports the result combinationally. A cycle can be claimed by one of three fixed legacy port decodes, by one of a set of programmable generic I/O windows, or by one of a set of programmable memory windows. If none of these matches, an optional subtractive fallback can still claim the cycle. The decoder reports how the cycle was claimed and the index of the decode that won.

Software sets the windows up through a simple word-addressed register port. Each window has a base register and a size register, and the size register holds the window length minus one. All enable bits sit in one shared decode-enable register. A separate global control register holds the subtractive-decode enable and a 2-bit target selector. A clear strobe returns the decode map to zero in one cycle but keeps the port-0x80 enable as it was.

Top module: `host_win_decoder`

## Requirements
- R1: The decode-enable register has three legacy enable bits, and each one applies to I/O cycles only. Bit 0 claims port 0x0080, bit 1 claims ports 0x0060 and 0x0064, and bit 2 claims ports 0x002E and 0x002F. A legacy claim sets `fixed_hit`, and `win_idx` gives 0, 1 or 2 in that same order.
- R2: Generic I/O window i lives at register word 0x08+i. Bits [15:0] hold the base and bits [23:16] hold the size minus one. The window matches an I/O cycle when base <= cyc_addr[15:0] <= base+size, and this sum does not wrap. Bits [31:16] of the address are ignored for I/O cycles.
- R3: Generic memory window j keeps its base at word 0x10+2j, with all 32 bits used. It keeps its size minus one at word 0x11+2j, in bits [15:0]. The window matches a memory cycle when base <= cyc_addr <= base+size, and this sum does not wrap.
- R4: A generic window can match only while its enable bit is set. The enable bit for I/O window i is bit 8+i of the decode-enable register, and the enable bit for memory window j is bit 16+j. A window whose enable bit is clear never matches, whatever its base and size hold.
- R5: A legacy decode wins over every generic window. When several generic windows match, the lowest-numbered one wins. At most one of `fixed_hit`, `win_hit` and `sub_claim` is high, and `claim` is their OR.
- R6: The global control register is word 0x01. Bit 0 enables subtractive decode and bits [2:1] select the target, which is always driven on `sub_target`. While bit 0 is set, a cycle that matches nothing raises `sub_claim`, and `win_idx` is 0.
- R7: A `clear_req` pulse zeroes every base register, every size register and every decode-enable bit except bit 0, which keeps its value. The global control register is not changed. The clear takes priority over a write in the same cycle.
- R8: A register write takes effect from the clock edge that samples `reg_we`. Reads are combinational. Bits that are not implemented read as zero, and bits of the decode-enable register with no window behind them cannot be written.
- R9: I/O windows and legacy decodes never claim memory cycles. Memory windows never claim I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| clear_req | input | 1 | Clears the decode map and keeps the port-0x80 enable |
| cyc_addr | input | 32 | Address of the host cycle |
| cyc_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| claim | output | 1 | The cycle is claimed by any route |
| fixed_hit | output | 1 | Claimed by a legacy port decode |
| win_hit | output | 1 | Claimed by a generic window |
| win_idx | output | 2 | Index of the winning legacy decode or window |
| sub_claim | output | 1 | Claimed subtractively |
| sub_target | output | 2 | Subtractive target selector |

## Verification
The bench builds the decoder with its default four I/O windows and four memory windows. With these defaults the whole 16-bit I/O space can be swept address by address against an arithmetic model. One sweep uses a map that contains overlapping windows, a window placed at the top of the I/O space, and a window that is disabled. Memory windows are checked at the addresses just below, at and just above each window edge, and one of these windows sits at the top of the 32-bit space. The same sweeps are repeated with the subtractive fallback on. Further checks cover the write-to-decode latency and the clear strobe, with the port-0x80 enable both set and clear.

// File: rtl/hdec_pkg.sv
package hdec_pkg;
    localparam int REG_AW = 6;

    // register word map
    localparam logic [REG_AW-1:0] RA_DEC_EN   = 6'h00;
    localparam logic [REG_AW-1:0] RA_GCTL     = 6'h01;
    localparam logic [REG_AW-1:0] RA_IO_WIN0  = 6'h08;
    localparam logic [REG_AW-1:0] RA_MEM_WIN0 = 6'h10;

    // decode-enable bit layout
    localparam int LEG_POST   = 0;
    localparam int LEG_KBC    = 1;
    localparam int LEG_SIO    = 2;
    localparam int NUM_LEG    = 3;
    localparam int EN_IO_LSB  = 8;
    localparam int EN_MEM_LSB = 16;

    localparam int IO_AW   = 16;
    localparam int IO_SW   = 8;
    localparam int MEM_AW  = 32;
    localparam int MEM_SW  = 16;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FIXED = 2'd1,
        SRC_WIN   = 2'd2,
        SRC_SUB   = 2'd3
    } src_e;
endpackage

// File: rtl/hdec_regs.sv
module hdec_regs
    import hdec_pkg::*;
#(
    parameter int N_IO  = 4,
    parameter int N_MEM = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [REG_AW-1:0]              addr_i,
    input  logic [31:0]                    wdata_i,
    input  logic                           clr_i,
    output logic [31:0]                    dec_en_o,
    output logic [2:0]                     gctl_o,
    output logic [N_IO-1:0][IO_AW-1:0]     io_base_o,
    output logic [N_IO-1:0][IO_SW-1:0]     io_size_o,
    output logic [N_MEM-1:0][MEM_AW-1:0]   mem_base_o,
    output logic [N_MEM-1:0][MEM_SW-1:0]   mem_size_o,
    output logic [31:0]                    rdata_o
);
    localparam logic [31:0] IO_EN_MASK  = 32'(((64'd1 << N_IO) - 64'd1) << EN_IO_LSB);
    localparam logic [31:0] MEM_EN_MASK = 32'(((64'd1 << N_MEM) - 64'd1) << EN_MEM_LSB);
    localparam logic [31:0] LEG_MASK    = 32'((64'd1 << NUM_LEG) - 64'd1);
    localparam logic [31:0] EN_MASK     = IO_EN_MASK | MEM_EN_MASK | LEG_MASK;
    localparam logic [31:0] KEEP_MASK   = 32'(64'd1 << LEG_POST);

    typedef struct packed {
        logic [31:0]                  dec_en;
        logic [2:0]                   gctl;
        logic [N_IO-1:0][IO_AW-1:0]   io_base;
        logic [N_IO-1:0][IO_SW-1:0]   io_size;
        logic [N_MEM-1:0][MEM_AW-1:0] mem_base;
        logic [N_MEM-1:0][MEM_SW-1:0] mem_size;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.dec_en   = st_q.dec_en & KEEP_MASK;
            st_d.io_base  = '0;
            st_d.io_size  = '0;
            st_d.mem_base = '0;
            st_d.mem_size = '0;
        end else if (we_i) begin
            if (addr_i == RA_DEC_EN) begin
                st_d.dec_en = wdata_i & EN_MASK;
            end
            if (addr_i == RA_GCTL) begin
                st_d.gctl = wdata_i[2:0];
            end
            for (int i = 0; i < N_IO; i++) begin
                if (addr_i == RA_IO_WIN0 + REG_AW'(i)) begin
                    st_d.io_base[i] = wdata_i[IO_AW-1:0];
                    st_d.io_size[i] = wdata_i[IO_AW +: IO_SW];
                end
            end
            for (int j = 0; j < N_MEM; j++) begin
                if (addr_i == RA_MEM_WIN0 + REG_AW'(2 * j)) begin
                    st_d.mem_base[j] = wdata_i;
                end
                if (addr_i == RA_MEM_WIN0 + REG_AW'(2 * j + 1)) begin
                    st_d.mem_size[j] = wdata_i[MEM_SW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == RA_DEC_EN) begin
            rdata_o = st_q.dec_en;
        end
        if (addr_i == RA_GCTL) begin
            rdata_o = {29'd0, st_q.gctl};
        end
        for (int i = 0; i < N_IO; i++) begin
            if (addr_i == RA_IO_WIN0 + REG_AW'(i)) begin
                rdata_o = 32'({st_q.io_size[i], st_q.io_base[i]});
            end
        end
        for (int j = 0; j < N_MEM; j++) begin
            if (addr_i == RA_MEM_WIN0 + REG_AW'(2 * j)) begin
                rdata_o = st_q.mem_base[j];
            end
            if (addr_i == RA_MEM_WIN0 + REG_AW'(2 * j + 1)) begin
                rdata_o = 32'(st_q.mem_size[j]);
            end
        end
    end

    assign dec_en_o   = st_q.dec_en;
    assign gctl_o     = st_q.gctl;
    assign io_base_o  = st_q.io_base;
    assign io_size_o  = st_q.io_size;
    assign mem_base_o = st_q.mem_base;
    assign mem_size_o = st_q.mem_size;
endmodule

// File: rtl/hdec_win_match.sv
module hdec_win_match #(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [SW-1:0] size_i,
    input  logic          en_i,
    output logic          hit_o
);
    logic [AW:0] last;

    // one extra bit so a window at the top of the space does not wrap
    assign last  = {1'b0, base_i} + {{(AW + 1 - SW){1'b0}}, size_i};
    assign hit_o = en_i && (addr_i >= base_i) && ({1'b0, addr_i} <= last);
endmodule

// File: rtl/hdec_prio.sv
module hdec_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/host_win_decoder.sv
module host_win_decoder
    import hdec_pkg::*;
#(
    parameter int N_IO  = 4,
    parameter int N_MEM = 4,
    localparam int N_WIN = (N_IO > N_MEM) ? N_IO : N_MEM,
    localparam int N_MAX = (N_WIN > NUM_LEG) ? N_WIN : NUM_LEG,
    localparam int IW    = $clog2(N_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              clear_req,
    input  logic [31:0]       cyc_addr,
    input  logic              cyc_is_mem,
    output logic              claim,
    output logic              fixed_hit,
    output logic              win_hit,
    output logic [IW-1:0]     win_idx,
    output logic              sub_claim,
    output logic [1:0]        sub_target
);
    logic [31:0]                  dec_en_q;
    logic [2:0]                   gctl_q;
    logic [N_IO-1:0][IO_AW-1:0]   io_base_q;
    logic [N_IO-1:0][IO_SW-1:0]   io_size_q;
    logic [N_MEM-1:0][MEM_AW-1:0] mem_base_q;
    logic [N_MEM-1:0][MEM_SW-1:0] mem_size_q;

    hdec_regs #(.N_IO(N_IO), .N_MEM(N_MEM)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .clr_i      (clear_req),
        .dec_en_o   (dec_en_q),
        .gctl_o     (gctl_q),
        .io_base_o  (io_base_q),
        .io_size_o  (io_size_q),
        .mem_base_o (mem_base_q),
        .mem_size_o (mem_size_q),
        .rdata_o    (reg_rdata)
    );

    logic              io_cyc;
    logic [IO_AW-1:0]  io_addr;
    logic [NUM_LEG-1:0] leg_req;
    logic [N_IO-1:0]   io_req;
    logic [N_MEM-1:0]  mem_req;

    assign io_cyc  = !cyc_is_mem;
    assign io_addr = cyc_addr[IO_AW-1:0];

    assign leg_req[LEG_POST] = io_cyc && dec_en_q[LEG_POST] && (io_addr == 16'h0080);
    assign leg_req[LEG_KBC]  = io_cyc && dec_en_q[LEG_KBC] &&
                               ((io_addr == 16'h0060) || (io_addr == 16'h0064));
    assign leg_req[LEG_SIO]  = io_cyc && dec_en_q[LEG_SIO] &&
                               ((io_addr == 16'h002E) || (io_addr == 16'h002F));

    for (genvar gi = 0; gi < N_IO; gi++) begin : g_io_win
        hdec_win_match #(.AW(IO_AW), .SW(IO_SW)) u_match (
            .addr_i (io_addr),
            .base_i (io_base_q[gi]),
            .size_i (io_size_q[gi]),
            .en_i   (io_cyc && dec_en_q[EN_IO_LSB + gi]),
            .hit_o  (io_req[gi])
        );
    end

    for (genvar gm = 0; gm < N_MEM; gm++) begin : g_mem_win
        hdec_win_match #(.AW(MEM_AW), .SW(MEM_SW)) u_match (
            .addr_i (cyc_addr),
            .base_i (mem_base_q[gm]),
            .size_i (mem_size_q[gm]),
            .en_i   (cyc_is_mem && dec_en_q[EN_MEM_LSB + gm]),
            .hit_o  (mem_req[gm])
        );
    end

    logic          leg_any, io_any, mem_any;
    logic [IW-1:0] leg_idx, io_idx, mem_idx;

    hdec_prio #(.N(NUM_LEG), .IW(IW)) u_leg_prio (
        .req_i (leg_req), .any_o (leg_any), .idx_o (leg_idx)
    );
    hdec_prio #(.N(N_IO), .IW(IW)) u_io_prio (
        .req_i (io_req), .any_o (io_any), .idx_o (io_idx)
    );
    hdec_prio #(.N(N_MEM), .IW(IW)) u_mem_prio (
        .req_i (mem_req), .any_o (mem_any), .idx_o (mem_idx)
    );

    src_e src;

    always_comb begin
        src     = SRC_NONE;
        win_idx = '0;
        if (leg_any) begin
            src     = SRC_FIXED;
            win_idx = leg_idx;
        end else if (io_any) begin
            src     = SRC_WIN;
            win_idx = io_idx;
        end else if (mem_any) begin
            src     = SRC_WIN;
            win_idx = mem_idx;
        end else if (gctl_q[0]) begin
            src     = SRC_SUB;
        end
    end

    assign fixed_hit  = (src == SRC_FIXED);
    assign win_hit    = (src == SRC_WIN);
    assign sub_claim  = (src == SRC_SUB);
    assign claim      = (src != SRC_NONE);
    assign sub_target = gctl_q[2:1];
endmodule

// File: rtl/hdec_chk.sv
module hdec_chk
    import hdec_pkg::*;
#(
    parameter int IW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_req,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [2:0]        wlow,
    input logic [31:0]       dec_en,
    input logic [2:0]        gctl,
    input logic              cyc_is_mem,
    input logic              claim,
    input logic              fixed_hit,
    input logic              win_hit,
    input logic [IW-1:0]     win_idx,
    input logic              sub_claim
);
    logic io_bit_set, mem_bit_set;

    assign io_bit_set  = ((dec_en >> (EN_IO_LSB + int'(win_idx))) & 32'h1) != 32'h0;
    assign mem_bit_set = ((dec_en >> (EN_MEM_LSB + int'(win_idx))) & 32'h1) != 32'h0;

    p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fixed_hit, win_hit, sub_claim}));

    p_claim_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (fixed_hit || win_hit || sub_claim));

    p_fixed_io_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_hit |-> !cyc_is_mem);

    p_io_win_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !cyc_is_mem) |-> io_bit_set);

    p_mem_win_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && cyc_is_mem) |-> mem_bit_set);

    p_sub_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_claim |-> gctl[0]);

    p_clear_keeps_post_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (dec_en == {31'd0, $past(dec_en[0])}));

    p_clear_keeps_gctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> $stable(gctl));

    p_gctl_write_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !clear_req && reg_addr == RA_GCTL) |=> (gctl == $past(wlow)));
endmodule

bind host_win_decoder hdec_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_req  (clear_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wlow       (reg_wdata[2:0]),
    .dec_en     (dec_en_q),
    .gctl       (gctl_q),
    .cyc_is_mem (cyc_is_mem),
    .claim      (claim),
    .fixed_hit  (fixed_hit),
    .win_hit    (win_hit),
    .win_idx    (win_idx),
    .sub_claim  (sub_claim)
);

// File: tb/host_win_decoder_tb.sv
module host_win_decoder_tb;
    localparam int NI = 4;
    localparam int NM = 4;
    localparam logic [31:0] EN_MASK = 32'h000F_0F07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clear_req = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_is_mem = 1'b0;
    logic        claim, fixed_hit, win_hit, sub_claim;
    logic [1:0]  win_idx, sub_target;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench-side copy of the programmed map
    logic [31:0] m_en;
    logic [2:0]  m_gctl;
    logic [15:0] m_iob [NI];
    logic [7:0]  m_ios [NI];
    logic [31:0] m_mb  [NM];
    logic [15:0] m_ms  [NM];

    host_win_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clear_req(clear_req),
        .cyc_addr(cyc_addr), .cyc_is_mem(cyc_is_mem), .claim(claim),
        .fixed_hit(fixed_hit), .win_hit(win_hit), .win_idx(win_idx),
        .sub_claim(sub_claim), .sub_target(sub_target)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic mirror_clear();
        m_en = m_en & 32'h1;
        for (int i = 0; i < NI; i++) begin m_iob[i] = '0; m_ios[i] = '0; end
        for (int j = 0; j < NM; j++) begin m_mb[j] = '0; m_ms[j] = '0; end
    endtask

    task automatic mirror_write(input logic [5:0] a, input logic [31:0] d);
        if (a == 6'h00) m_en = d & EN_MASK;
        if (a == 6'h01) m_gctl = d[2:0];
        for (int i = 0; i < NI; i++)
            if (a == 6'(8 + i)) begin m_iob[i] = d[15:0]; m_ios[i] = d[23:16]; end
        for (int j = 0; j < NM; j++) begin
            if (a == 6'(16 + 2 * j)) m_mb[j] = d;
            if (a == 6'(17 + 2 * j)) m_ms[j] = d[15:0];
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        mirror_write(a, d);
    endtask

    task automatic clr();
        @(negedge clk);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        mirror_clear();
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read word %h: got=%h exp=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic cyc_chk(input logic mem, input logic [31:0] a, input string tag);
        logic e_fix, e_win, e_sub, e_claim;
        logic [1:0] e_idx;
        logic [15:0] a16;
        a16 = a[15:0];
        e_fix = 0; e_win = 0; e_sub = 0; e_idx = 0;
        if (!mem) begin
            if (m_en[0] && a16 == 16'h0080) begin e_fix = 1; e_idx = 0; end
            else if (m_en[1] && (a16 == 16'h0060 || a16 == 16'h0064)) begin e_fix = 1; e_idx = 1; end
            else if (m_en[2] && (a16 == 16'h002E || a16 == 16'h002F)) begin e_fix = 1; e_idx = 2; end
            if (!e_fix) begin
                for (int i = NI - 1; i >= 0; i--) begin
                    if (m_en[8 + i] && ({1'b0, a16} >= {1'b0, m_iob[i]}) &&
                        ({1'b0, a16} <= {1'b0, m_iob[i]} + {9'd0, m_ios[i]})) begin
                        e_win = 1; e_idx = 2'(i);
                    end
                end
            end
        end else begin
            for (int j = NM - 1; j >= 0; j--) begin
                if (m_en[16 + j] && ({1'b0, a} >= {1'b0, m_mb[j]}) &&
                    ({1'b0, a} <= {1'b0, m_mb[j]} + {17'd0, m_ms[j]})) begin
                    e_win = 1; e_idx = 2'(j);
                end
            end
        end
        if (!e_fix && !e_win && m_gctl[0]) e_sub = 1;
        e_claim = e_fix | e_win | e_sub;
        cyc_is_mem = mem;
        cyc_addr = a;
        #1;
        n_chk++;
        if ({claim, fixed_hit, win_hit, sub_claim, win_idx, sub_target} !==
            {e_claim, e_fix, e_win, e_sub, e_idx, m_gctl[2:1]}) begin
            n_bad++;
            $display("FAIL %s mem=%0d addr=%h got=%b exp=%b", tag, mem, a,
                {claim, fixed_hit, win_hit, sub_claim, win_idx, sub_target},
                {e_claim, e_fix, e_win, e_sub, e_idx, m_gctl[2:1]});
        end
    endtask

    task automatic mem_edges(input string tag);
        for (int j = 0; j < NM; j++) begin
            cyc_chk(1'b1, m_mb[j] - 32'd1, tag);
            cyc_chk(1'b1, m_mb[j], tag);
            cyc_chk(1'b1, m_mb[j] + 32'(m_ms[j] >> 1), tag);
            cyc_chk(1'b1, m_mb[j] + 32'(m_ms[j]), tag);
            cyc_chk(1'b1, m_mb[j] + 32'(m_ms[j]) + 32'd1, tag);
        end
        cyc_chk(1'b1, 32'h0000_0080, tag);
        cyc_chk(1'b1, 32'h0000_0100, tag);
        cyc_chk(1'b0, 32'h1000_0005, tag);
        cyc_chk(1'b0, 32'h2000_0000, tag);
    endtask

    task automatic io_sweep(input int top, input string tag);
        for (int a = 0; a <= top; a++) cyc_chk(1'b0, 32'(a), tag);
    endtask

    initial begin
        m_en = '0; m_gctl = '0;
        for (int i = 0; i < NI; i++) begin m_iob[i] = '0; m_ios[i] = '0; end
        for (int j = 0; j < NM; j++) begin m_mb[j] = '0; m_ms[j] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: everything reads zero, nothing claimed (R8, R1)
        rd_chk(6'h00, 32'h0, "R8 reset");
        rd_chk(6'h01, 32'h0, "R8 reset");
        rd_chk(6'h08, 32'h0, "R8 reset");
        rd_chk(6'h16, 32'h0, "R8 reset");
        cyc_chk(1'b0, 32'h80, "R1 reset");

        // program a map with overlaps and edge windows
        wr(6'h08, 32'hAB0F_0100);
        wr(6'h09, 32'hAB1F_0108);
        wr(6'h0A, 32'hABFF_FF00);
        wr(6'h0B, 32'hAB07_0060);
        wr(6'h10, 32'h1000_0000); wr(6'h11, 32'hABCD_FFFF);
        wr(6'h12, 32'h1000_8000); wr(6'h13, 32'h0000_00FF);
        wr(6'h14, 32'hFFFF_FF00); wr(6'h15, 32'h0000_00FF);
        wr(6'h16, 32'h2000_0000); wr(6'h17, 32'h0000_0000);
        wr(6'h00, 32'hFFF7_F7FF);

        rd_chk(6'h00, 32'h0007_0707, "R8 enable mask");
        rd_chk(6'h08, 32'h000F_0100, "R2 readback");
        rd_chk(6'h0B, 32'h0007_0060, "R2 readback");
        rd_chk(6'h11, 32'h0000_FFFF, "R3 readback");
        rd_chk(6'h14, 32'hFFFF_FF00, "R3 readback");
        rd_chk(6'h3F, 32'h0, "R8 unmapped");

        io_sweep(65535, "R2/R4/R5/R1 io sweep");
        mem_edges("R3/R4/R9 mem edges");

        wr(6'h00, 32'h000F_0F07);
        io_sweep(1023, "R4/R5 all enabled");
        mem_edges("R4/R5 all enabled");

        wr(6'h01, 32'hFFFF_FFF6);
        rd_chk(6'h01, 32'h6, "R8 gctl");
        cyc_chk(1'b0, 32'h0000_0200, "R6 sub off");
        wr(6'h01, 32'h0000_0005);
        io_sweep(1023, "R6 sub io");
        mem_edges("R6 sub mem");

        // write latency: old map holds until the sampling edge (R8)
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h000F_0E07;
        cyc_chk(1'b0, 32'h0000_0100, "R8 before edge");
        @(negedge clk);
        reg_we = 1'b0;
        mirror_write(6'h00, 32'h000F_0E07);
        cyc_chk(1'b0, 32'h0000_0100, "R8 after edge");
        cyc_chk(1'b0, 32'h0000_0108, "R8 after edge");

        // clear keeps port-0x80 enable and global control (R7)
        clr();
        rd_chk(6'h00, 32'h1, "R7 keep post");
        rd_chk(6'h01, 32'h5, "R7 keep gctl");
        rd_chk(6'h09, 32'h0, "R7 io cleared");
        rd_chk(6'h12, 32'h0, "R7 mem cleared");
        rd_chk(6'h13, 32'h0, "R7 mem cleared");
        cyc_chk(1'b0, 32'h80, "R7 post still decoded");
        cyc_chk(1'b0, 32'h60, "R7 kbc gone");
        cyc_chk(1'b1, 32'h1000_0000, "R7 mem gone");

        wr(6'h00, 32'h0);
        cyc_chk(1'b0, 32'h80, "R1 post disabled");
        // clear wins over a same-cycle write
        @(negedge clk);
        clear_req = 1'b1; reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h000F_0F07;
        @(negedge clk);
        clear_req = 1'b0; reg_we = 1'b0;
        mirror_clear();
        rd_chk(6'h00, 32'h0, "R7 clear over write");
        cyc_chk(1'b0, 32'h2E, "R7 clear over write");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule